// File: doc/BRIEF.md
# Mono Repeat-Mode Serial Audio Transmitter

This block takes mono audio samples from a small on-chip transmit queue and shifts them out on a serial data line that follows I2S timing. A word clock (WS) splits each frame into a low half and a high half. The block sends the same sample in both halves: first while WS is low, then again while WS is high. The bit clock (BCLK) and WS come from an external clock master. The block oversamples both with its own system clock. It drives the data line one system-clock register after each BCLK falling edge, so the receiver can sample it on the following rising edge.

Software or a DMA engine writes 32-bit words through a push port. Each word holds one sample in its low bits. The sample width is selected at 8, 16, 24 or 32 bits. The queue depth is eight words. A level output and a refill flag show when more data should be written. The flag is raised when the level is at or below a programmed threshold. If the master runs each half longer than the sample, zeros fill the remaining bit slots. This covers the case of a 32-clock channel carrying a short sample.

The serializer is a three-state machine:
- **IDLE**: Until the first WS-low half is seen, the block stays here and sends zeros. It moves to SHIFT on the first BCLK fall after a WS-low start is detected.
- **SHIFT**: The block shifts out one sample copy, MSB first.
  - On each BCLK fall it stays in SHIFT while bits remain.
  - It reloads within SHIFT when a new half has started.
  - It moves to FILL once the LSB has been sent.
- **FILL**: The block drives zeros. It moves back to SHIFT on the first BCLK fall after the next WS transition.

Top module: `i2s_mono_repeat_tx`

## Requirements
- R1: The MSB of each sample copy is the value on `sdo` at the second BCLK rising edge after a WS transition. The LSB of the previous half is at the first of those rising edges.
- R2: The sample latched when a WS-low half starts is sent again, bit for bit, in the WS-high half that follows.
- R3: `size_sel` selects the sample width: 0 = 8 bits, 1 = 16, 2 = 24, 3 = 32. The sample is bits [N-1:0] of the queue word. Bits above N are never sent.
- R4: After the LSB of a copy, `sdo` is 0 for every further bit slot until the next WS transition. This is how a 32-clock half pads a shorter sample.
- R5: When each WS half is exactly N bit clocks long, consecutive halves carry consecutive copies with no gap bits.
- R6: The queue holds 8 words. `fifo_full` is 1 at 8 words, and a push while full is dropped, so neither the level nor the data order changes.
- R7: `level` gives the number of stored words. A word is removed when the LSB of its WS-high copy is driven. After reset, `level` is 0.
- R8: `thr_flag` is 1 exactly when `level` is less than or equal to `thresh`.
- R9: If the queue is empty when a WS-low half starts, both halves of that frame carry zeros and `underrun` becomes 1 and stays 1 until reset.
- R10: After reset, `sdo` is 0 until the first WS-low half begins. A WS-high half seen first sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than BCLK |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock from the external master |
| ws | input | 1 | Word select from the external master (0 = first copy, 1 = repeat) |
| wr_en | input | 1 | Push strobe for the transmit queue |
| wr_data | input | 32 | Queue word, sample right-aligned |
| fifo_full | output | 1 | Queue holds 8 words |
| size_sel | input | 2 | Sample width code (0:8, 1:16, 2:24, 3:32) |
| thresh | input | 4 | Refill threshold level |
| level | output | 4 | Current number of stored words |
| thr_flag | output | 1 | Level at or below threshold |
| sdo | output | 1 | Serial data output |
| underrun | output | 1 | Sticky flag: a frame started with an empty queue |

## Verification
The bench sends frames with halves exactly as long as the sample and with 32-clock halves around 8-bit samples. A design that is off by one BCLK would show every word shifted by one bit against the expected MSB position. A design that does not zero-pad would leak the unused upper bits of the word into the padded slots. Filling the queue and pushing a ninth word tests the full boundary: a design that overwrote an entry would send the wrong sample in one of the eight drained frames. Draining into an empty queue must produce zero frames and a raised sticky flag. A design that popped at the low half would show a different sample in the repeat copy.

// File: rtl/i2s_mono_tx_pkg.sv
package i2s_mono_tx_pkg;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_24 = 2'd2,
        SZ_32 = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SHIFT = 2'd1,
        TX_FILL  = 2'd2
    } tx_state_e;

    function automatic int sample_bits(input size_e sz);
        int n;
        unique case (sz)
            SZ_8:    n = 8;
            SZ_16:   n = 16;
            SZ_24:   n = 24;
            default: n = 32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/i2s_tx_edge.sv
module i2s_tx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic ws,
    output logic rise,
    output logic fall,
    output logic ws_s
);
    logic [STAGES-1:0] bsync_q;
    logic [STAGES-1:0] wsync_q;
    logic              bclk_d_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsync_q  <= '0;
            wsync_q  <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            bsync_q  <= {bsync_q[STAGES-2:0], bclk};
            wsync_q  <= {wsync_q[STAGES-2:0], ws};
            bclk_d_q <= bsync_q[STAGES-1];
        end
    end

    assign rise = bsync_q[STAGES-1] & ~bclk_d_q;
    assign fall = ~bsync_q[STAGES-1] & bclk_d_q;
    assign ws_s = wsync_q[STAGES-1];
endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [LW-1:0]    count
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [LW-1:0]    cnt_q;
    logic             wr_ok, rd_ok;

    assign full  = (cnt_q == LW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign wr_ok = push & ~full;
    assign rd_ok = pop & ~empty;
    assign head  = mem_q[rptr_q];
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[wptr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (rd_ok) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_mono_tx_pkg::*;
#(
    parameter int DW = 32,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  logic          ws_i,
    input  logic [1:0]    size_sel,
    input  logic [DW-1:0] head,
    input  logic          empty,
    output logic          pop,
    output logic          sdo,
    output logic          underrun
);
    tx_state_e     state_q, state_d;
    logic          synced_q, ws_last_q, pend_q, pend_hi_q;
    logic [DW-1:0] cur_q, shreg_q;
    logic          cur_ok_q, half_hi_q, sdo_q, unr_q;
    logic [CW-1:0] left_q, nbits;
    logic          load;

    assign nbits = CW'(sample_bits(size_e'(size_sel)));
    assign load  = fall & pend_q & ((state_q != TX_IDLE) | ~pend_hi_q);
    assign pop   = fall & (state_q == TX_SHIFT) & ~pend_q & (left_q == CW'(1))
                 & half_hi_q & cur_ok_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (fall && pend_q && !pend_hi_q) state_d = TX_SHIFT;
            TX_SHIFT: if (fall && !pend_q && left_q == '0) state_d = TX_FILL;
            TX_FILL:  if (fall && pend_q) state_d = TX_SHIFT;
            default:  state_d = TX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q  <= 1'b0;
            ws_last_q <= 1'b0;
            pend_q    <= 1'b0;
            pend_hi_q <= 1'b0;
            cur_q     <= '0;
            cur_ok_q  <= 1'b0;
            half_hi_q <= 1'b0;
            shreg_q   <= '0;
            left_q    <= '0;
            sdo_q     <= 1'b0;
            unr_q     <= 1'b0;
        end else begin
            if (rise) begin
                if (!synced_q) begin
                    synced_q  <= 1'b1;
                    ws_last_q <= ws_i;
                end else if (ws_i != ws_last_q) begin
                    ws_last_q <= ws_i;
                    pend_q    <= 1'b1;
                    pend_hi_q <= ws_i;
                    if (!ws_i) begin
                        cur_q    <= empty ? '0 : head;
                        cur_ok_q <= ~empty;
                        if (empty) unr_q <= 1'b1;
                    end
                end
            end
            if (fall) begin
                pend_q <= 1'b0;
                if (load) begin
                    half_hi_q <= pend_hi_q;
                    shreg_q   <= cur_q << (CW'(DW) - nbits);
                    sdo_q     <= cur_q[nbits - 1'b1];
                    left_q    <= nbits - 1'b1;
                end else if (state_q == TX_SHIFT && left_q != '0) begin
                    sdo_q   <= shreg_q[DW-2];
                    shreg_q <= shreg_q << 1;
                    left_q  <= left_q - 1'b1;
                end else begin
                    sdo_q <= 1'b0;
                end
            end
        end
    end

    assign sdo      = sdo_q;
    assign underrun = unr_q;
endmodule

// File: rtl/i2s_mono_repeat_tx.sv
module i2s_mono_repeat_tx #(
    parameter int DW     = 32,
    parameter int DEPTH  = 8,
    parameter int STAGES = 2,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk,
    input  logic          ws,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          fifo_full,
    input  logic [1:0]    size_sel,
    input  logic [LW-1:0] thresh,
    output logic [LW-1:0] level,
    output logic          thr_flag,
    output logic          sdo,
    output logic          underrun
);
    logic          rise_p, fall_p, ws_s;
    logic          pop_w, fifo_empty;
    logic [DW-1:0] head_w;

    i2s_tx_edge #(.STAGES(STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws),
        .rise(rise_p), .fall(fall_p), .ws_s(ws_s)
    );

    i2s_tx_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_data),
        .pop(pop_w), .head(head_w), .full(fifo_full),
        .empty(fifo_empty), .count(level)
    );

    i2s_tx_serializer #(.DW(DW)) ser_i (
        .clk(clk), .rst_n(rst_n), .rise(rise_p), .fall(fall_p), .ws_i(ws_s),
        .size_sel(size_sel), .head(head_w), .empty(fifo_empty),
        .pop(pop_w), .sdo(sdo), .underrun(underrun)
    );

    assign thr_flag = (level <= thresh);
endmodule

// File: rtl/i2s_mono_repeat_tx_chk.sv
module i2s_mono_repeat_tx_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sdo,
    input logic          fall,
    input logic          pop,
    input logic          empty,
    input logic          underrun,
    input logic          wr_en,
    input logic          fifo_full,
    input logic [LW-1:0] level
);
    assert_level_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && wr_en && !pop |=> level == $past(level));

    assert_pop_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    assert_sdo_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(fall));
endmodule

bind i2s_mono_repeat_tx i2s_mono_repeat_tx_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
    .clk(clk), .rst_n(rst_n), .sdo(sdo), .fall(fall_p), .pop(pop_w),
    .empty(fifo_empty), .underrun(underrun), .wr_en(wr_en),
    .fifo_full(fifo_full), .level(level)
);

// File: tb/i2s_mono_repeat_tx_tb.sv
module i2s_mono_repeat_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, bclk, ws, wr_en;
    logic [31:0] wr_data;
    logic [1:0]  size_sel;
    logic [3:0]  thresh, level;
    logic        fifo_full, thr_flag, sdo, underrun;

    int   checks = 0;
    int   errors = 0;
    int   sp = 0;
    logic sbits [0:8191];

    always #2 clk = ~clk;

    i2s_mono_repeat_tx dut_i (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .ws(ws), .wr_en(wr_en),
        .wr_data(wr_data), .fifo_full(fifo_full), .size_sel(size_sel),
        .thresh(thresh), .level(level), .thr_flag(thr_flag), .sdo(sdo),
        .underrun(underrun)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // one bit slot: falling edge (WS may change), then rising edge
    task automatic bit_period(input logic w);
        @(negedge clk); bclk = 1'b0; ws = w;
        repeat (8) @(negedge clk);
        sbits[sp] = sdo; sp++;
        bclk = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic run_frames(input int hl, input int nf, output int start);
        start = sp;
        for (int f = 0; f < nf; f++) begin
            for (int i = 0; i < hl; i++) bit_period(1'b0);
            for (int i = 0; i < hl; i++) bit_period(1'b1);
        end
        bit_period(1'b1);
    endtask

    task automatic check_half(input int start, input int h, input int hl, input int n,
                              input logic [31:0] smp, input string tag);
        logic [31:0] g = '0;
        logic [31:0] e = '0;
        for (int k = 0; k < hl; k++) begin
            g[31-k] = sbits[start + h*hl + 1 + k];
            e[31-k] = (k < n) ? smp[n-1-k] : 1'b0;
        end
        chk(g == e, tag, $sformatf("half %0d bits", h), g, e);
    endtask

    task automatic t_reset();
        chk(level == 4'd0, "R7", "reset level", 32'(level), 32'd0);
        chk(fifo_full == 1'b0, "R6", "reset full", 32'(fifo_full), 32'd0);
        chk(underrun == 1'b0, "R9", "reset underrun", 32'(underrun), 32'd0);
        chk(thr_flag == 1'b1, "R8", "reset flag", 32'(thr_flag), 32'd1);
        for (int i = 0; i < 4; i++) bit_period(1'b1);
        chk(sdo == 1'b0, "R10", "idle sdo", 32'(sdo), 32'd0);
        for (int i = 0; i < 4; i++) chk(sbits[i] == 1'b0, "R10", "idle bit", 32'(sbits[i]), 32'd0);
    endtask

    task automatic t_threshold();
        push(32'hDEADA5C3);
        push(32'h00001234);
        chk(level == 4'd2, "R7", "level after 2", 32'(level), 32'd2);
        chk(thr_flag == 1'b1, "R8", "flag at equal", 32'(thr_flag), 32'd1);
        push(32'h0000F00F);
        chk(thr_flag == 1'b0, "R8", "flag above", 32'(thr_flag), 32'd0);
    endtask

    task automatic t_basic();
        int st;
        size_sel = 2'd1;
        run_frames(16, 3, st);
        check_half(st, 0, 16, 16, 32'h0000A5C3, "R1 R3");
        check_half(st, 1, 16, 16, 32'h0000A5C3, "R2");
        check_half(st, 2, 16, 16, 32'h00001234, "R5");
        check_half(st, 3, 16, 16, 32'h00001234, "R2");
        check_half(st, 4, 16, 16, 32'h0000F00F, "R5");
        check_half(st, 5, 16, 16, 32'h0000F00F, "R2");
        chk(level == 4'd0, "R7", "level drained", 32'(level), 32'd0);
        chk(underrun == 1'b0, "R9", "no underrun", 32'(underrun), 32'd0);
    endtask

    task automatic t_extended();
        int st;
        size_sel = 2'd0;
        push(32'hFFFFFF5A);
        push(32'h00000081);
        run_frames(32, 2, st);
        for (int h = 0; h < 4; h++)
            check_half(st, h, 32, 8, (h < 2) ? 32'h5A : 32'h81, "R4");
    endtask

    task automatic t_wide();
        int st;
        size_sel = 2'd2;
        push(32'hFFABCDEF);
        run_frames(24, 1, st);
        check_half(st, 0, 24, 24, 32'h00ABCDEF, "R3");
        check_half(st, 1, 24, 24, 32'h00ABCDEF, "R3");
        size_sel = 2'd3;
        push(32'h80000001);
        push(32'hCAFEF00D);
        run_frames(32, 2, st);
        for (int h = 0; h < 4; h++)
            check_half(st, h, 32, 32, (h < 2) ? 32'h80000001 : 32'hCAFEF00D, "R3");
    endtask

    task automatic t_full();
        int st;
        size_sel = 2'd0;
        for (int i = 0; i < 8; i++) push(32'h100 + 32'(i * 17 + 3));
        chk(fifo_full == 1'b1, "R6", "full at 8", 32'(fifo_full), 32'd1);
        chk(level == 4'd8, "R6", "level 8", 32'(level), 32'd8);
        push(32'h000000EE);
        chk(level == 4'd8, "R6", "push while full", 32'(level), 32'd8);
        run_frames(8, 8, st);
        for (int h = 0; h < 16; h++)
            check_half(st, h, 8, 8, 32'((h / 2) * 17 + 3), "R6 R5");
        chk(level == 4'd0, "R7", "level after drain", 32'(level), 32'd0);
        chk(underrun == 1'b0, "R9", "still no underrun", 32'(underrun), 32'd0);
    endtask

    task automatic t_underrun();
        int st;
        run_frames(8, 1, st);
        check_half(st, 0, 8, 8, 32'h0, "R9");
        check_half(st, 1, 8, 8, 32'h0, "R9");
        chk(underrun == 1'b1, "R9", "underrun set", 32'(underrun), 32'd1);
        repeat (20) @(negedge clk);
        chk(underrun == 1'b1, "R9", "underrun sticky", 32'(underrun), 32'd1);
    endtask

    initial begin
        rst_n = 1'b0; bclk = 1'b1; ws = 1'b1; wr_en = 1'b0; wr_data = '0;
        size_sel = 2'd1; thresh = 4'd2;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_basic();
        t_extended();
        t_wide();
        t_full();
        t_underrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule